// File: doc/BRIEF.md
# Overflow and Underflow Response Unit

This unit sits after the rounder of an extended-precision arithmetic pipeline. The result it receives has already been judged to overflow or to underflow. It applies the response the exception masks call for and passes the final destination value, its class tag and the exception requests on to the register file and the status unit. When the relevant exception is masked, it substitutes a default value: infinity for overflow, and for underflow either zero or a denormalised significand. When the exception is unmasked, it keeps the significand and wraps the exponent by a fixed amount of 3×8192, so that a trap handler can rebuild the true value.

The incoming exponent is a 17-bit signed working exponent `e`. The unbiased true exponent uses a bias of 16383, and the underflow limit `L` is -16383. The output exponent field is 15 bits wide. Wherever a rule below writes "low15(x)", the field holds the low 15 bits of the two's-complement value x. A result is accepted in any cycle in which `in_valid` is high, and it appears registered one cycle later.

Top module: `ovr_resp_top`

## Requirements
- R1: While `rst` is high and on the first edge after it, every output is 0. In any cycle in which `out_valid` is low, every request output is 0.
- R2: A result presented with `in_valid` high at one rising edge appears on the outputs with `out_valid` high after exactly that edge. With `in_valid` low, `out_valid` is low one edge later.
- R3: A masked overflow (`mask_ovf`=1) gives exponent field 0x7FFF and significand 0x8000_0000_0000_0000. The input sign is kept and `out_tag` is 2 (special).
- R4: A masked overflow raises `req_ovf`, `req_prec` and `req_c1_set`. It leaves `req_c1_clr` and `out_unmasked` low.
- R5: An unmasked overflow gives exponent field low15(e − 24576) and keeps the significand, with tag 0 (valid). Only `req_ovf` and `out_unmasked` are raised.
- R6: A masked underflow with e ≤ L − 63 (that is, e ≤ -16446) gives exponent field 0 and significand 0, keeps the sign, and has tag 1 (zero).
- R7: A masked underflow with L − 63 < e ≤ L shifts the significand right by L + 1 − e places (1 to 63), with exponent field 0. With e > L it gives field low15(e + 16383) and keeps the significand. Either way the tag is 0.
- R8: Every masked underflow raises `req_unf`, `req_prec` and `req_c1_clr`. It leaves `req_c1_set` and `out_unmasked` low.
- R9: An unmasked underflow gives exponent field low15(e + 24576 + 16383) and keeps the significand, with tag 0. Only `req_unf` and `out_unmasked` are raised.
- R10: When both `in_ovf` and `in_unf` are set, the result is handled as an overflow. The underflow mask has no effect on an overflow result, and `req_ovf` and `req_unf` are never high together.
- R11: With neither flag set, the unit passes the value through: exponent field low15(e + 16383), significand and sign unchanged, tag 0, and no request raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Result present this cycle |
| in_ovf | input | 1 | Result flagged as overflowing |
| in_unf | input | 1 | Result flagged as underflowing |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 17 | Signed working exponent, unbiased |
| in_sig | input | 64 | Significand, explicit integer bit at the top |
| mask_ovf | input | 1 | Overflow exception masked |
| mask_unf | input | 1 | Underflow exception masked |
| out_valid | output | 1 | Final result present |
| out_sign | output | 1 | Final sign |
| out_exp | output | 15 | Final biased exponent field |
| out_sig | output | 64 | Final significand |
| out_tag | output | 2 | Class tag: 0 valid, 1 zero, 2 special |
| req_ovf | output | 1 | Overflow exception request |
| req_unf | output | 1 | Underflow exception request |
| req_prec | output | 1 | Follow-on precision exception request |
| req_c1_set | output | 1 | Request to set condition bit C1 (rounded up) |
| req_c1_clr | output | 1 | Request to clear condition bit C1 |
| out_unmasked | output | 1 | Primary exception is unmasked; pulses with the result |

## Verification
Every output of this unit, including the value, the tag and all six request bits, passes through a single register stage. A result driven before rising edge k is therefore due right after edge k, and an idle input clears the outputs after the next edge. The bench changes inputs on falling edges and reads outputs on the following falling edge, half a period after the capturing edge. It checks the value, tag, request bits and `out_valid` in that same sample. The cycle after the last vector is read to confirm the idle state, and a reset raised behind a pending result is read one edge later to confirm it was discarded.

// File: rtl/ovr_resp_pkg.sv
package ovr_resp_pkg;

    localparam int SIG_W      = 64;
    localparam int EXP_W      = 15;
    localparam int WEXP_W     = 17;
    localparam int SH_W       = $clog2(SIG_W);
    localparam int BIAS       = 16383;
    localparam int WRAP       = 3 * 8192;
    localparam int UNF_LIMIT  = -BIAS;
    localparam int FLUSH_SPAN = SIG_W - 1;

    typedef logic signed [WEXP_W-1:0] wexp_t;

    localparam wexp_t BIAS_W      = wexp_t'(BIAS);
    localparam wexp_t WRAP_W      = wexp_t'(WRAP);
    localparam wexp_t SHIFT_BASE  = wexp_t'(UNF_LIMIT + 1);
    localparam wexp_t FLUSH_SHIFT = wexp_t'(FLUSH_SPAN + 1);

    localparam logic [SIG_W-1:0] INF_SIG = {1'b1, {(SIG_W-1){1'b0}}};

    typedef enum logic [1:0] {
        TAG_VALID   = 2'd0,
        TAG_ZERO    = 2'd1,
        TAG_SPECIAL = 2'd2
    } tag_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        tag_e             tag;
    } res_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic prec;
        logic c1_set;
        logic c1_clr;
        logic unmasked;
    } req_t;

    localparam req_t REQ_NONE = '{default: 1'b0};

    function automatic logic [EXP_W-1:0] to_field(wexp_t value);
        return value[EXP_W-1:0];
    endfunction

endpackage

// File: rtl/ovr_resp_rshift.sv
module ovr_resp_rshift #(
    parameter int W  = 64,
    parameter int SW = 6
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amount,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amount[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/ovr_resp_ovf.sv
module ovr_resp_ovf
    import ovr_resp_pkg::*;
(
    input  logic             sign,
    input  wexp_t            e,
    input  logic [SIG_W-1:0] sig,
    input  logic             masked,
    output res_t             res,
    output req_t             req
);
    wexp_t wrapped;

    always_comb begin
        wrapped = e - WRAP_W;
        req     = REQ_NONE;
        req.ovf = 1'b1;
        if (masked) begin
            res.sign   = sign;
            res.exp    = '1;
            res.sig    = INF_SIG;
            res.tag    = TAG_SPECIAL;
            req.prec   = 1'b1;
            req.c1_set = 1'b1;
        end else begin
            res.sign     = sign;
            res.exp      = to_field(wrapped);
            res.sig      = sig;
            res.tag      = TAG_VALID;
            req.unmasked = 1'b1;
        end
    end
endmodule

// File: rtl/ovr_resp_unf.sv
module ovr_resp_unf
    import ovr_resp_pkg::*;
(
    input  logic             sign,
    input  wexp_t            e,
    input  logic [SIG_W-1:0] sig,
    input  logic             masked,
    output res_t             res,
    output req_t             req
);
    wexp_t             shift_full;
    wexp_t             wrapped;
    wexp_t             rebias;
    logic              flush;
    logic              denorm;
    logic [SH_W-1:0]   amount;
    logic [SIG_W-1:0]  shifted;

    always_comb begin
        shift_full = SHIFT_BASE - e;
        flush      = (shift_full >= FLUSH_SHIFT);
        denorm     = (shift_full > 0) && !flush;
        amount     = denorm ? shift_full[SH_W-1:0] : '0;
        wrapped    = e + WRAP_W + BIAS_W;
        rebias     = e + BIAS_W;
    end

    ovr_resp_rshift #(.W(SIG_W), .SW(SH_W)) u_shift (
        .din    (sig),
        .amount (amount),
        .dout   (shifted)
    );

    always_comb begin
        req      = REQ_NONE;
        req.unf  = 1'b1;
        res.sign = sign;
        if (masked) begin
            req.prec   = 1'b1;
            req.c1_clr = 1'b1;
            if (flush) begin
                res.exp = '0;
                res.sig = '0;
                res.tag = TAG_ZERO;
            end else if (denorm) begin
                res.exp = '0;
                res.sig = shifted;
                res.tag = TAG_VALID;
            end else begin
                res.exp = to_field(rebias);
                res.sig = sig;
                res.tag = TAG_VALID;
            end
        end else begin
            req.unmasked = 1'b1;
            res.exp      = to_field(wrapped);
            res.sig      = sig;
            res.tag      = TAG_VALID;
        end
    end
endmodule

// File: rtl/ovr_resp_top.sv
module ovr_resp_top
    import ovr_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ovf,
    input  logic              in_unf,
    input  logic              in_sign,
    input  logic [WEXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              mask_ovf,
    input  logic              mask_unf,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [SIG_W-1:0]  out_sig,
    output logic [1:0]        out_tag,
    output logic              req_ovf,
    output logic              req_unf,
    output logic              req_prec,
    output logic              req_c1_set,
    output logic              req_c1_clr,
    output logic              out_unmasked
);
    wexp_t e;
    res_t  ovf_res, unf_res, pass_res, sel_res, res_q;
    req_t  ovf_req, unf_req, sel_req, req_q;
    logic  valid_q;

    assign e = wexp_t'(in_exp);

    ovr_resp_ovf u_ovf (
        .sign   (in_sign),
        .e      (e),
        .sig    (in_sig),
        .masked (mask_ovf),
        .res    (ovf_res),
        .req    (ovf_req)
    );

    ovr_resp_unf u_unf (
        .sign   (in_sign),
        .e      (e),
        .sig    (in_sig),
        .masked (mask_unf),
        .res    (unf_res),
        .req    (unf_req)
    );

    always_comb begin
        pass_res.sign = in_sign;
        pass_res.exp  = to_field(e + BIAS_W);
        pass_res.sig  = in_sig;
        pass_res.tag  = TAG_VALID;
    end

    // Overflow takes precedence when both flags arrive together.
    always_comb begin
        if (in_ovf) begin
            sel_res = ovf_res;
            sel_req = ovf_req;
        end else if (in_unf) begin
            sel_res = unf_res;
            sel_req = unf_req;
        end else begin
            sel_res = pass_res;
            sel_req = REQ_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            req_q   <= REQ_NONE;
        end else if (in_valid) begin
            valid_q <= 1'b1;
            res_q   <= sel_res;
            req_q   <= sel_req;
        end else begin
            valid_q <= 1'b0;
            res_q   <= '0;
            req_q   <= REQ_NONE;
        end
    end

    assign out_valid    = valid_q;
    assign out_sign     = res_q.sign;
    assign out_exp      = res_q.exp;
    assign out_sig      = res_q.sig;
    assign out_tag      = res_q.tag;
    assign req_ovf      = req_q.ovf;
    assign req_unf      = req_q.unf;
    assign req_prec     = req_q.prec;
    assign req_c1_set   = req_q.c1_set;
    assign req_c1_clr   = req_q.c1_clr;
    assign out_unmasked = req_q.unmasked;
endmodule

// File: rtl/ovr_resp_checker.sv
module ovr_resp_checker
    import ovr_resp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ovf,
    input logic              in_unf,
    input logic              mask_ovf,
    input logic              mask_unf,
    input logic              out_valid,
    input logic [EXP_W-1:0]  out_exp,
    input logic [SIG_W-1:0]  out_sig,
    input logic [1:0]        out_tag,
    input logic              req_ovf,
    input logic              req_unf,
    input logic              req_prec,
    input logic              req_c1_set,
    input logic              req_c1_clr,
    input logic              out_unmasked
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(req_ovf || req_unf || req_prec || req_c1_set || req_c1_clr || out_unmasked));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_inf_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ovf && mask_ovf) |=>
        (out_tag == 2'd2 && out_exp == '1 && out_sig == INF_SIG));

    assert_roundup_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_ovf && !out_unmasked) |-> (req_prec && req_c1_set && !req_c1_clr));

    assert_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
        out_unmasked |-> (!req_prec && !req_c1_set && !req_c1_clr && out_tag == 2'd0));

    assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag == 2'd1) |-> (out_sig == '0 && out_exp == '0 && req_unf));

    assert_masked_unf_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ovf && in_unf && mask_unf) |=>
        (req_unf && req_prec && req_c1_clr && !req_c1_set && !out_unmasked));

    assert_priority_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_ovf && req_unf));

    assert_no_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ovf && !in_unf) |=> !(req_ovf || req_unf || req_prec));
endmodule

bind ovr_resp_top ovr_resp_checker u_ovr_resp_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ovf       (in_ovf),
    .in_unf       (in_unf),
    .mask_ovf     (mask_ovf),
    .mask_unf     (mask_unf),
    .out_valid    (out_valid),
    .out_exp      (out_exp),
    .out_sig      (out_sig),
    .out_tag      (out_tag),
    .req_ovf      (req_ovf),
    .req_unf      (req_unf),
    .req_prec     (req_prec),
    .req_c1_set   (req_c1_set),
    .req_c1_clr   (req_c1_clr),
    .out_unmasked (out_unmasked)
);

// File: tb/test_ovr_resp_top.sv
module test_ovr_resp_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] S  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] IN = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [7:0]  rq;
        logic        ovf, unf, sg;
        logic [16:0] e;
        logic [63:0] sig;
        logic        mo, mu;
        logic [14:0] xe;
        logic [63:0] xs;
        logic [1:0]  xt;
        logic [5:0]  xr;   // {ovf, unf, prec, c1_set, c1_clr, unmasked}
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  1'b1, 1'b0, 1'b1,  17'sd16400, S, 1'b1, 1'b1, 15'h7FFF, IN, 2'd2, 6'b101100}, // R3 R4
        '{8'd5,  1'b1, 1'b0, 1'b0,  17'sd16400, S, 1'b0, 1'b1, 15'h6010, S,  2'd0, 6'b100001}, // R5
        '{8'd5,  1'b1, 1'b0, 1'b1,  17'sd40000, S, 1'b0, 1'b0, 15'h3C40, S,  2'd0, 6'b100001}, // R5
        '{8'd9,  1'b0, 1'b1, 1'b0, -17'sd16400, S, 1'b1, 1'b0, 15'h5FEF, S,  2'd0, 6'b010001}, // R9
        '{8'd6,  1'b0, 1'b1, 1'b1, -17'sd16446, S, 1'b1, 1'b1, 15'h0000, 64'd0, 2'd1, 6'b011010}, // R6 R8
        '{8'd6,  1'b0, 1'b1, 1'b0, -17'sd20000, 64'h1234, 1'b1, 1'b1, 15'h0000, 64'd0, 2'd1, 6'b011010}, // R6
        '{8'd7,  1'b0, 1'b1, 1'b0, -17'sd16445, S, 1'b0, 1'b1, 15'h0000, 64'd1, 2'd0, 6'b011010}, // R7 R8
        '{8'd7,  1'b0, 1'b1, 1'b0, -17'sd16384, S, 1'b0, 1'b1, 15'h0000, 64'h3000_0000_0000_0000, 2'd0, 6'b011010}, // R7
        '{8'd7,  1'b0, 1'b1, 1'b1, -17'sd16383, S, 1'b0, 1'b1, 15'h0000, 64'h6000_0000_0000_0000, 2'd0, 6'b011010}, // R7
        '{8'd7,  1'b0, 1'b1, 1'b0, -17'sd16382, S, 1'b0, 1'b1, 15'h0001, S,  2'd0, 6'b011010}, // R7
        '{8'd10, 1'b1, 1'b1, 1'b0,  17'sd16400, S, 1'b1, 1'b0, 15'h7FFF, IN, 2'd2, 6'b101100}, // R10
        '{8'd10, 1'b1, 1'b0, 1'b0,  17'sd16400, S, 1'b0, 1'b0, 15'h6010, S,  2'd0, 6'b100001}, // R10
        '{8'd11, 1'b0, 1'b0, 1'b1,  17'sd0,     S, 1'b1, 1'b1, 15'h3FFF, S,  2'd0, 6'b000000}, // R11
        '{8'd11, 1'b0, 1'b0, 1'b0,  17'sd5,     64'hFFFF, 1'b0, 1'b0, 15'h4004, 64'hFFFF, 2'd0, 6'b000000} // R11
    };

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_ovf = 1'b0, in_unf = 1'b0, in_sign = 1'b0;
    logic [16:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic mask_ovf = 1'b0, mask_unf = 1'b0;
    logic out_valid, out_sign;
    logic [14:0] out_exp;
    logic [63:0] out_sig;
    logic [1:0] out_tag;
    logic req_ovf, req_unf, req_prec, req_c1_set, req_c1_clr, out_unmasked;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovr_resp_top i_ovr_resp_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ovf(in_ovf), .in_unf(in_unf),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .mask_ovf(mask_ovf), .mask_unf(mask_unf),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
        .out_tag(out_tag), .req_ovf(req_ovf), .req_unf(req_unf), .req_prec(req_prec),
        .req_c1_set(req_c1_set), .req_c1_clr(req_c1_clr), .out_unmasked(out_unmasked)
    );

    function automatic logic [5:0] reqs();
        return {req_ovf, req_unf, req_prec, req_c1_set, req_c1_clr, out_unmasked};
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1; in_ovf = v.ovf; in_unf = v.unf; in_sign = v.sg;
        in_exp = v.e; in_sig = v.sig; mask_ovf = v.mo; mask_unf = v.mu;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string t;
        t = $sformatf("R%0d vec%0d", v.rq, idx);
        check({t, " valid R2"}, 64'(out_valid), 64'd1);
        check({t, " sign"}, 64'(out_sign), 64'(v.sg));
        check({t, " exp"}, 64'(out_exp), 64'(v.xe));
        check({t, " sig"}, out_sig, v.xs);
        check({t, " tag"}, 64'(out_tag), 64'(v.xt));
        check({t, " requests (R4 R8)"}, 64'(reqs()), 64'(v.xr));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset reqs", 64'(reqs()), 64'd0);
        check("R1 reset exp/tag", {32'd0, 15'(out_exp), 15'd0, out_tag}, 64'd0);
        rst = 1'b0;

        // Vector table, one result per cycle, back to back
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i], i);
        end

        // R2 and R1: idle input clears outputs one edge later
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", 64'(out_valid), 64'd0);
        check("R1 idle reqs", 64'(reqs()), 64'd0);

        // R1: reset behind a pending result discards it
        drive(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset over pending valid", 64'(out_valid), 64'd0);
        check("R1 reset over pending reqs", 64'(reqs()), 64'd0);
        rst = 1'b0;

        // R10: underflow mask toggled on an overflow result has no effect
        drive(VECS[1]);
        mask_unf = 1'b0;
        @(negedge clk);
        check_vec(VECS[1], 1);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule